// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one IEEE-754 single-precision number by another over several clock cycles. A caller presents both operands and pulses `start`. The block then works out the result sign and the biased exponent. It builds the quotient significand one bit per clock with a non-restoring add/subtract recurrence. At the end it repairs the final partial remainder and uses it as a sticky bit. It normalizes by at most one place and rounds to nearest-even.

The packed quotient appears together with a one-cycle `done` pulse and stays on the outputs until the next `done`. Some operand combinations cannot give a normal result: a zero divisor, a subnormal, infinite or NaN operand, or a result exponent outside the normal range. In each of these cases the block raises `trap` in place of a result. Operand decode, the recurrence and the final round/pack stage are separate submodules, and the exponent and fraction widths are parameters.

Top module: `fpdiv_top`

## Requirements
- R1: For every result that does not trap, quotient bit 31 (the sign) is the XOR of bit 31 of the dividend and bit 31 of the divisor. This holds for zero results too.
- R2: Operands use the format sign[31], biased exponent[30:23] (bias 127), fraction[22:0]. When both operands are normal (exponent 1..254), the quotient is the exact ratio rounded to nearest, ties to even, and packed in the same format.
- R3: A zero dividend (exponent 0, fraction 0, either sign) divided by a normal divisor gives a signed zero with `trap` low. `done` comes on the short path: it is high in the cycle after the first rising edge that follows the accepting edge.
- R4: A zero divisor raises `trap` with quotient 0, whatever the dividend is, zero included. It takes the short path.
- R5: An operand that is subnormal (exponent 0, fraction nonzero), infinite or NaN (exponent 255) raises `trap` with quotient 0 on the short path. This check wins over the zero cases.
- R6: If the rounded result exponent would be above 254 or below 1, `trap` is raised and the quotient is 0. Results at exponent 254 or 1 are delivered normally.
- R7: `done` is high for exactly one cycle. For normal operands it is high in the cycle that follows the 27th rising edge after the edge that accepted `start`, which is one edge per quotient bit (26) plus one for packing.
- R8: `start` is ignored while an operation is in progress. Between `done` pulses, `quotient` and `trap` keep their values whatever the inputs do.
- R9: While reset is asserted (`rst_n` low), `done`, `trap` and `quotient` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only when idle |
| dividend | input | 32 | Numerator, single-precision |
| divisor | input | 32 | Denominator, single-precision |
| done | output | 1 | One-cycle pulse marking a new result |
| quotient | output | 32 | Packed result, 0 when trapping |
| trap | output | 1 | Operand or range error for the last operation |

## Verification
Suppose the recurrence takes a wrong add/subtract decision, mis-corrects the final remainder or uses a wrong sticky bit. The damage shows at the ports in the low fraction bits and the rounding of the very next result, 27 edges after acceptance. A broad sweep of operand pairs, compared against a long-division model in the bench, catches it on the first affected pair. A wrong step counter or state decode shows up as the `done` pulse arriving on the wrong edge. A fault in the operand classification shows as a trap on the short path when a value was expected, or the other way round.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

   // Sequencer phases of the divider
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_PACK = 2'd2
   } fpdiv_state_e;

endpackage

// File: rtl/fpdiv_unpack.sv
// Splits one packed operand into fields and classifies it.
module fpdiv_unpack #(
   parameter  int EXP_W  = 8,
   parameter  int FRAC_W = 23,
   localparam int TOT_W  = 1 + EXP_W + FRAC_W,
   localparam int MANT_W = FRAC_W + 1
) (
   input  logic [TOT_W-1:0]  word,
   output logic              sgn,
   output logic [EXP_W-1:0]  expo,
   output logic [MANT_W-1:0] mant,
   output logic              is_zero,
   output logic              is_bad
);

   logic [FRAC_W-1:0] frac;
   logic              exp_lo;
   logic              exp_hi;

   always_comb begin
      sgn     = word[TOT_W-1];
      expo    = word[TOT_W-2:FRAC_W];
      frac    = word[FRAC_W-1:0];
      exp_lo  = (expo == '0);
      exp_hi  = &expo;
      is_zero = exp_lo && (frac == '0);
      // subnormal, infinity and NaN are all refused
      is_bad  = exp_hi || (exp_lo && (frac != '0));
      mant    = {1'b1, frac};
   end

endmodule

// File: rtl/fpdiv_nr_core.sv
// Non-restoring significand divider: one quotient bit per step.
// The partial remainder carries three zero guard bits above the significand,
// so the dividend enters already shifted down relative to the register and
// no significant bit can be lost while it is doubled.
module fpdiv_nr_core #(
   parameter  int MANT_W = 24,
   localparam int QBITS  = MANT_W + 2,
   localparam int RW     = MANT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [MANT_W-1:0] dvd_m,
   input  logic [MANT_W-1:0] dvs_m,
   output logic [QBITS-1:0]  qbits,
   output logic              rem_nz
);

   logic signed [RW-1:0] part_r;
   logic [MANT_W-1:0]    dvs_r;
   logic [QBITS-1:0]     q_r;
   logic                 sub_nxt;

   logic signed [RW-1:0] dvs_ext;
   logic signed [RW-1:0] trial;
   logic signed [RW-1:0] fixed_rem;
   logic                 qbit;

   always_comb begin
      dvs_ext   = signed'({{(RW-MANT_W){1'b0}}, dvs_r});
      trial     = sub_nxt ? (part_r - dvs_ext) : (part_r + dvs_ext);
      qbit      = ~trial[RW-1];
      // after the last step the remainder is already doubled: a negative
      // outcome is repaired with twice the divisor
      fixed_rem = sub_nxt ? part_r : (part_r + (dvs_ext <<< 1));
      rem_nz    = (fixed_rem != '0);
      qbits     = q_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_r  <= '0;
         dvs_r   <= '0;
         q_r     <= '0;
         sub_nxt <= 1'b1;
      end else if (load) begin
         part_r  <= signed'({{(RW-MANT_W){1'b0}}, dvd_m});
         dvs_r   <= dvs_m;
         q_r     <= '0;
         sub_nxt <= 1'b1;
      end else if (step) begin
         part_r  <= trial <<< 1;
         q_r     <= {q_r[QBITS-2:0], qbit};
         sub_nxt <= qbit;
      end
   end

endmodule

// File: rtl/fpdiv_round.sv
// One-place normalization, nearest-even rounding, range check and packing.
module fpdiv_round #(
   parameter  int EXP_W   = 8,
   parameter  int FRAC_W  = 23,
   localparam int TOT_W   = 1 + EXP_W + FRAC_W,
   localparam int MANT_W  = FRAC_W + 1,
   localparam int QBITS   = MANT_W + 2,
   localparam int EW      = EXP_W + 2,
   localparam int EXP_MAX = (1 << EXP_W) - 1
) (
   input  logic [QBITS-1:0] qbits,
   input  logic             rem_nz,
   input  logic             sgn,
   input  logic [EW-1:0]    ediff,
   output logic [TOT_W-1:0] packed_q,
   output logic             range_err
);

   logic              hi;
   logic [MANT_W-1:0] mant_pre;
   logic              rnd;
   logic              stk;
   logic              inc;
   logic [MANT_W:0]   sum;
   logic [EW-1:0]     e_fin;

   always_comb begin
      hi       = qbits[QBITS-1];
      mant_pre = hi ? qbits[QBITS-1:2] : qbits[QBITS-2:1];
      rnd      = hi ? qbits[1] : qbits[0];
      stk      = rem_nz | (hi & qbits[0]);
      inc      = rnd & (stk | mant_pre[0]);
      sum      = {1'b0, mant_pre} + {{MANT_W{1'b0}}, inc};
      e_fin    = ediff - EW'(!hi) + EW'(sum[MANT_W]);
      range_err = e_fin[EW-1] | (e_fin == '0) | (e_fin >= EW'(EXP_MAX));
      // on a rounding carry the stored fraction bits are all zero
      packed_q = {sgn, e_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
   end

endmodule

// File: rtl/fpdiv_top.sv
module fpdiv_top #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [EXP_W+FRAC_W:0]       dividend,
   input  logic [EXP_W+FRAC_W:0]       divisor,
   output logic                        done,
   output logic [EXP_W+FRAC_W:0]       quotient,
   output logic                        trap
);
   import fpdiv_pkg::*;

   localparam int TOT_W  = 1 + EXP_W + FRAC_W;
   localparam int MANT_W = FRAC_W + 1;
   localparam int QBITS  = MANT_W + 2;
   localparam int EW     = EXP_W + 2;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int CNT_W  = $clog2(QBITS);

   if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
      $error("fpdiv_top: EXP_W out of supported range");
   end
   if (FRAC_W < 4 || FRAC_W > 52) begin : g_bad_frac
      $error("fpdiv_top: FRAC_W out of supported range");
   end

   // ---------------- operand decode ----------------
   logic [TOT_W-1:0]  opw     [2];
   logic              sgn_w   [2];
   logic [EXP_W-1:0]  exp_w   [2];
   logic [MANT_W-1:0] mant_w  [2];
   logic              zero_w  [2];
   logic              bad_w   [2];

   assign opw[0] = dividend;
   assign opw[1] = divisor;

   for (genvar g = 0; g < 2; g++) begin : g_unp
      fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .word    (opw[g]),
         .sgn     (sgn_w[g]),
         .expo    (exp_w[g]),
         .mant    (mant_w[g]),
         .is_zero (zero_w[g]),
         .is_bad  (bad_w[g])
      );
   end

   logic          spec_trap;
   logic          spec_zero;
   logic [EW-1:0] ediff_next;

   always_comb begin
      spec_trap  = bad_w[0] | bad_w[1] | zero_w[1];
      spec_zero  = zero_w[0] & ~spec_trap;
      ediff_next = EW'(exp_w[0]) - EW'(exp_w[1]) + EW'(BIAS);
   end

   // ---------------- sequencer ----------------
   fpdiv_state_e     state;
   logic [CNT_W-1:0] cnt;
   logic             sgn_r;
   logic [EW-1:0]    ediff_r;
   logic             sp_trap_r;
   logic             sp_zero_r;
   logic             accept;

   assign accept = start && (state == ST_IDLE);

   // ---------------- datapath ----------------
   logic [QBITS-1:0] qbits;
   logic             rem_nz;
   logic [TOT_W-1:0] packed_q;
   logic             range_err;

   fpdiv_nr_core #(.MANT_W(MANT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .step   (state == ST_ITER),
      .dvd_m  (mant_w[0]),
      .dvs_m  (mant_w[1]),
      .qbits  (qbits),
      .rem_nz (rem_nz)
   );

   fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .qbits     (qbits),
      .rem_nz    (rem_nz),
      .sgn       (sgn_r),
      .ediff     (ediff_r),
      .packed_q  (packed_q),
      .range_err (range_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sgn_r     <= 1'b0;
         ediff_r   <= '0;
         sp_trap_r <= 1'b0;
         sp_zero_r <= 1'b0;
         done      <= 1'b0;
         quotient  <= '0;
         trap      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  sgn_r     <= sgn_w[0] ^ sgn_w[1];
                  ediff_r   <= ediff_next;
                  sp_trap_r <= spec_trap;
                  sp_zero_r <= spec_zero;
                  cnt       <= '0;
                  state     <= (spec_trap | spec_zero) ? ST_PACK : ST_ITER;
               end
            end
            ST_ITER: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(QBITS - 1)) state <= ST_PACK;
            end
            ST_PACK: begin
               done  <= 1'b1;
               trap  <= sp_trap_r | (~sp_zero_r & range_err);
               if (sp_trap_r)       quotient <= '0;
               else if (sp_zero_r)  quotient <= {sgn_r, {(TOT_W-1){1'b0}}};
               else if (range_err)  quotient <= '0;
               else                 quotient <= packed_q;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fpdiv_chk.sv
// Port-level protocol and result checker, bound to the divider.
module fpdiv_chk #(
   parameter  int EXP_W  = 8,
   parameter  int FRAC_W = 23,
   localparam int TOT_W  = 1 + EXP_W + FRAC_W,
   localparam int QBITS  = FRAC_W + 3,
   localparam int CW     = $clog2(QBITS + 4)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [TOT_W-1:0] dividend,
   input logic [TOT_W-1:0] divisor,
   input logic             done,
   input logic [TOT_W-1:0] quotient,
   input logic             trap
);

   logic          busy_c;
   logic [CW-1:0] cnt_c;
   logic          sgn_c;
   logic          zdvd_c;
   logic          take;
   logic [EXP_W-1:0] dexp;
   logic          dvs_normal;

   always_comb begin
      take       = start && (!busy_c || done);
      dexp       = divisor[TOT_W-2:FRAC_W];
      dvs_normal = (dexp != '0) && !(&dexp) && (divisor[TOT_W-2:0] != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         cnt_c  <= '0;
         sgn_c  <= 1'b0;
         zdvd_c <= 1'b0;
      end else if (take) begin
         busy_c <= 1'b1;
         cnt_c  <= '0;
         sgn_c  <= dividend[TOT_W-1] ^ divisor[TOT_W-1];
         zdvd_c <= (dividend[TOT_W-2:0] == '0) && dvs_normal;
      end else if (done) begin
         busy_c <= 1'b0;
      end else if (busy_c && cnt_c != '1) begin
         cnt_c <= cnt_c + 1'b1;
      end
   end

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_c && (cnt_c == CW'(QBITS + 1) || cnt_c == CW'(1))));

   assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !trap) |-> (quotient[TOT_W-1] == sgn_c));

   assert_trap_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && trap) |-> (quotient == '0));

   assert_zero_dividend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zdvd_c) |-> (!trap && quotient[TOT_W-2:0] == '0 && cnt_c == CW'(1)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(trap)));

endmodule

bind fpdiv_top fpdiv_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .dividend (dividend),
   .divisor  (divisor),
   .done     (done),
   .quotient (quotient),
   .trap     (trap)
);

// File: tb/fpdiv_top_tb.sv
module fpdiv_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LAT_LONG   = 28;  // sampled negedges incl. the accepting one
   localparam int LAT_SHORT  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor  = '0;
   logic        done;
   logic [31:0] quotient;
   logic        trap;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpdiv_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dividend (dividend),
      .divisor  (divisor),
      .done     (done),
      .quotient (quotient),
      .trap     (trap)
   );

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // expected {short_path, trap, quotient} by long division
   function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
      logic [7:0]  ea, eb;
      logic [22:0] fa, fb;
      logic        bad_a, bad_b, za, zb, s;
      logic [63:0] num, qq, rm, mb;
      logic [24:0] m;
      logic        r, st;
      int          e;
      ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
      s  = a[31] ^ b[31];
      bad_a = (ea == 8'hFF) || (ea == 0 && fa != 0);
      bad_b = (eb == 8'hFF) || (eb == 0 && fb != 0);
      za = (ea == 0 && fa == 0);
      zb = (eb == 0 && fb == 0);
      if (bad_a || bad_b || zb) return {1'b1, 1'b1, 32'h0};
      if (za) return {1'b1, 1'b0, s, 31'h0};
      num = {40'h0, 1'b1, fa} << 25;
      mb  = {40'h0, 1'b1, fb};
      qq  = num / mb;
      rm  = num % mb;
      e   = int'(ea) - int'(eb) + 127;
      if (qq[25]) begin
         m = {1'b0, qq[25:2]}; r = qq[1]; st = (rm != 0) || qq[0];
      end else begin
         m = {1'b0, qq[24:1]}; r = qq[0]; st = (rm != 0); e = e - 1;
      end
      if (r && (st || m[0])) m = m + 1;
      if (m[24]) begin m = 25'h0800000; e = e + 1; end
      if (e < 1 || e > 254) return {1'b0, 1'b1, 32'h0};
      return {1'b0, 1'b0, s, 8'(e), m[22:0]};
   endfunction

   function automatic logic [31:0] mix(input logic [31:0] x0);
      logic [31:0] x;
      x = x0;
      x = x ^ (x >> 16);
      x = x * 32'h7feb352d;
      x = x ^ (x >> 15);
      x = x * 32'h846ca68b;
      x = x ^ (x >> 16);
      return x;
   endfunction

   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
      logic [33:0] exp;
      int lat;
      exp = model(a, b);
      @(negedge clk);
      dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(done && quotient == exp[31:0] && trap == exp[32], req,
            {31'h0, trap, quotient}, {31'h0, exp[32], exp[31:0]});
      check(lat == (exp[33] ? LAT_SHORT : LAT_LONG), "R7 latency",
            64'(lat), 64'(exp[33] ? LAT_SHORT : LAT_LONG));
      @(negedge clk);
      check(!done, "R7 single pulse", {63'h0, done}, 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(!done && quotient == 0 && !trap, "R9 reset",
            {31'h0, done ^ trap, quotient}, 64'h0);
      rst_n = 1'b1;

      // R2: known values
      run_op(32'h3F800000, 32'h3F800000, "R2 one/one");
      check(quotient == 32'h3F800000, "R2 one/one const", {32'h0, quotient}, 64'h3F800000);
      run_op(32'h3F800000, 32'h40400000, "R2 one/three");
      check(quotient == 32'h3EAAAAAB, "R2 one/three const", {32'h0, quotient}, 64'h3EAAAAAB);
      // R1: signs
      run_op(32'h40C00000, 32'hC0000000, "R1 six/neg two");
      check(quotient == 32'hC0400000, "R1 neg three const", {32'h0, quotient}, 64'hC0400000);
      run_op(32'hC0C00000, 32'hC0000000, "R1 neg/neg");
      // R3: zero dividend
      run_op(32'h00000000, 32'h40000000, "R3 +0/2");
      run_op(32'h80000000, 32'h40000000, "R3 -0/2");
      run_op(32'h00000000, 32'hC0400000, "R3 +0/-3");
      // R4: zero divisor
      run_op(32'h40A00000, 32'h00000000, "R4 5/0");
      run_op(32'h00000000, 32'h80000000, "R4 0/-0");
      run_op(32'hC0A00000, 32'h80000000, "R4 -5/-0");
      // R5: bad operands
      run_op(32'h00000001, 32'h3F800000, "R5 subnormal dividend");
      run_op(32'h3F800000, 32'h00400000, "R5 subnormal divisor");
      run_op(32'h7F800000, 32'h3F800000, "R5 infinity");
      run_op(32'h3F800000, 32'h7FC00000, "R5 NaN");
      run_op(32'h00000000, 32'hFF800000, "R5 zero by infinity");
      // R6: range edges
      run_op(32'h7F000000, 32'h00800000, "R6 overflow");
      run_op(32'h00800000, 32'h7F000000, "R6 underflow");
      run_op(32'h7F7FFFFF, 32'h3F800000, "R6 top exponent");
      run_op(32'h00800000, 32'h3F800000, "R6 bottom exponent");
      run_op(32'h00800000, 32'h3FC00000, "R6 below bottom");

      // R8: start during a run is ignored, outputs hold
      begin
         logic [33:0] exp;
         logic [31:0] held;
         int lat;
         exp = model(32'h41200000, 32'h40E00000);
         @(negedge clk);
         dividend = 32'h41200000; divisor = 32'h40E00000; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (4) @(negedge clk);
         dividend = 32'h00000000; divisor = 32'h00000000; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat = 6;
         while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
         end
         check(quotient == exp[31:0] && !trap, "R8 ignored start result",
               {32'h0, quotient}, {32'h0, exp[31:0]});
         check(lat == LAT_LONG, "R8 ignored start latency", 64'(lat), 64'(LAT_LONG));
         held = quotient;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            dividend = mix(32'(k)); divisor = mix(32'(k + 50));
         end
         check(quotient == held && !trap && !done, "R8 hold",
               {32'h0, quotient}, {32'h0, held});
      end

      // R2/R6 sweep
      for (int i = 0; i < 400; i++) begin
         logic [31:0] h1, h2, a, b;
         logic [22:0] fa, fb;
         h1 = mix(32'(2 * i + 1));
         h2 = mix(32'(2 * i + 2));
         fa = h1[22:0];
         fb = h2[22:0];
         if (i % 16 == 0) fa = '1;
         if (i % 16 == 1) fb = '1;
         if (i % 16 == 2) fa = '0;
         if (i % 16 == 3) fb = '0;
         a = {h1[31], 8'(64 + int'(h1[30:24])), fa};
         b = {h2[31], 8'(64 + int'(h2[30:24])), fb};
         if (i % 50 == 7) a[30:23] = 8'd254;
         if (i % 50 == 9) b[30:23] = 8'd1;
         run_op(a, b, model(a, b) >> 32 == 2'b01 ? "R6 sweep" : "R2 sweep");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule